// File: doc/BRIEF.md
# Vertical Microcode Sequencer

This block is the control unit of a small accumulator machine, built as a vertically encoded microprogram. Each 10-bit microword has one of two formats. A register-transfer word holds three encoded fields: a source, a destination and a program-counter action. Decoders next to the store expand each field into one-hot datapath strobes. A branch word drives no strobes. It picks one of four condition inputs, compares it with a stored bit, and loads its 5-bit target into the micro-program counter when the two match.

The store holds a fixed 31-word program. The program fetches an instruction and splits on two instruction bits into load, store, add and branch-on-zero routines. It waits on the memory handshake by jumping back to the same access word. The datapath is outside this block. The sequencer only issues strobes and reads status bits. The current micro-address is brought out so that the sequence can be observed.

Top module: `usq_sequencer`

## Requirements
- R1: While `rst_n` is low, `upc` is 0 and every strobe output, `alu_add` and `is_branch` are 0. After `rst_n` rises, they stay so for two rising edges. Word 0 is then presented, and execution starts from address 0.
- R2: Bit 9 of a microword selects its format: 0 is register-transfer and 1 is branch. `is_branch` is high exactly in cycles that present a branch word.
- R3: After a register-transfer word, `upc` advances by one, wrapping modulo 32.
- R4: A branch word has its condition select in bits 8:7, its compare bit in bit 6 and its target in bits 4:0. When the selected condition equals the compare bit, the next `upc` is the target.
- R5: When the selected condition differs from the compare bit, `upc` advances by one.
- R6: A branch word raises none of `src_stb`, `dst_stb`, `pc_stb` or `alu_add`.
- R7: In a register-transfer word, bits 6:4 are the source code and bits 3:1 are the destination code. Code k > 0 raises only line k-1 of `src_stb` or `dst_stb`, and code 0 raises none.
- R8: Bits 8:7 of a register-transfer word are the program-counter action. Code 1 raises clear (`pc_stb[0]`), code 2 raises increment (`pc_stb[1]`) and code 3 raises load (`pc_stb[2]`). Code 0 raises none, so at most one line is high.
- R9: `alu_add` follows bit 0 of a register-transfer word.
- R10: At address 2 (fetch read), when `mem_wait` is 0 the sequencer returns to address 1. The memory-access word is therefore re-issued until the wait signal rises.
- R11: Addresses 0 to 30 hold the fetch/decode/load/store/add/branch program described in the trade-offs note, and address 31 holds an all-zero word. Instruction bit 15 set leads to the add or branch routine. Bit 14 then picks branch (when bit 15 is set) or store (when bit 15 is clear).
- R12: Condition select code 0 chooses `mem_wait`, 1 chooses `ir_bit15`, 2 chooses `ir_bit14` and 3 chooses `acc_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_wait | input | 1 | Memory handshake status |
| ir_bit15 | input | 1 | Instruction register bit 15 |
| ir_bit14 | input | 1 | Instruction register bit 14 |
| acc_zero | input | 1 | Accumulator equals zero |
| upc | output | 5 | Current micro-program address |
| src_stb | output | 7 | Decoded bus-source strobes |
| dst_stb | output | 7 | Decoded bus-destination strobes |
| pc_stb | output | 3 | Program-counter clear / increment / load |
| alu_add | output | 1 | ALU adds (low means pass) |
| is_branch | output | 1 | Current word is a branch word |

## Verification
Random condition inputs, biased toward a high wait signal, drive every routine, and a reference walk of the program predicts each address and strobe set. One target is the wait loop at address 2. Its branch is taken on a zero compare, so a design that inverted the compare would leave fetch early and then hang in the wait loops. Pairs of back-to-back branches model an unconditional jump. A sequencer that swapped taken and fall-through, or mis-ordered the condition select, would end up at the wrong routine within a few cycles. A reset asserted in the middle of a run checks that the strobes stay quiet through the release window, where a design without the synchronizer would issue word 0 one cycle early.

// File: rtl/usq_pkg.sv
package usq_pkg;

  localparam int UW_W   = 10;             // microword width
  localparam int UA_W   = 5;              // micro-address width
  localparam int FLD_W  = 3;              // source / destination field width
  localparam int STB_N  = (1 << FLD_W) - 1;
  localparam int PCF_W  = 2;              // program-counter action field width
  localparam int PCS_N  = (1 << PCF_W) - 1;
  localparam int SEL_W  = 2;              // condition select width
  localparam int COND_N = 1 << SEL_W;
  localparam int DEPTH  = 1 << UA_W;

  typedef enum logic [SEL_W-1:0] {
    CS_WAIT = 2'd0, CS_IR15 = 2'd1, CS_IR14 = 2'd2, CS_ACZ = 2'd3
  } cond_sel_e;

  typedef enum logic [FLD_W-1:0] {
    SRC_NONE, SRC_PC_A, SRC_IR_A, SRC_MBR_A,
    SRC_AC_R, SRC_ALU_R, SRC_MEM_D, SRC_MBR_D
  } src_e;

  typedef enum logic [FLD_W-1:0] {
    DST_NONE, DST_A_IR, DST_A_MAR, DST_R_AC,
    DST_R_MBR, DST_D_MBR, DST_MAR_ADR, DST_SPARE
  } dst_e;

  typedef enum logic [PCF_W-1:0] {
    PCO_HOLD, PCO_CLR, PCO_INC, PCO_LOAD
  } pc_op_e;

  typedef struct packed {
    logic   fmt;
    pc_op_e pc;
    src_e   src;
    dst_e   dst;
    logic   add;
  } rt_word_t;

  typedef struct packed {
    logic            fmt;
    cond_sel_e       sel;
    logic            val;
    logic            rsv;
    logic [UA_W-1:0] tgt;
  } bj_word_t;

  function automatic logic [UW_W-1:0] mk_rt(pc_op_e p, src_e s, dst_e d, logic a);
    return {1'b0, p, s, d, a};
  endfunction

  function automatic logic [UW_W-1:0] mk_bj(cond_sel_e c, logic v, logic [UA_W-1:0] t);
    return {1'b1, c, v, 1'b0, t};
  endfunction

endpackage

// File: rtl/usq_store.sv
module usq_store
  import usq_pkg::*;
(
  input  logic [UA_W-1:0] addr,
  output logic [UW_W-1:0] word
);

  always_comb begin
    unique case (addr)
      // fetch
      5'd0:  word = mk_rt(PCO_INC,  SRC_PC_A,  DST_A_MAR,   1'b0);
      5'd1:  word = mk_rt(PCO_HOLD, SRC_MEM_D, DST_MAR_ADR, 1'b0);
      5'd2:  word = mk_bj(CS_WAIT, 1'b0, 5'd1);
      5'd3:  word = mk_rt(PCO_HOLD, SRC_MEM_D, DST_D_MBR,   1'b0);
      5'd4:  word = mk_bj(CS_WAIT, 1'b1, 5'd3);
      5'd5:  word = mk_rt(PCO_HOLD, SRC_MBR_A, DST_A_IR,    1'b0);
      5'd6:  word = mk_bj(CS_WAIT, 1'b0, 5'd5);
      5'd7:  word = mk_rt(PCO_HOLD, SRC_IR_A,  DST_A_MAR,   1'b0);
      // decode
      5'd8:  word = mk_bj(CS_IR15, 1'b1, 5'd20);
      5'd9:  word = mk_bj(CS_IR14, 1'b1, 5'd16);
      // load
      5'd10: word = mk_rt(PCO_HOLD, SRC_MEM_D, DST_MAR_ADR, 1'b0);
      5'd11: word = mk_rt(PCO_HOLD, SRC_MEM_D, DST_D_MBR,   1'b0);
      5'd12: word = mk_bj(CS_WAIT, 1'b1, 5'd11);
      5'd13: word = mk_rt(PCO_HOLD, SRC_ALU_R, DST_R_AC,    1'b0);
      5'd14: word = mk_bj(CS_WAIT, 1'b0, 5'd0);
      5'd15: word = mk_bj(CS_WAIT, 1'b1, 5'd0);
      // store
      5'd16: word = mk_rt(PCO_HOLD, SRC_AC_R,  DST_R_MBR,   1'b0);
      5'd17: word = mk_rt(PCO_HOLD, SRC_MBR_D, DST_MAR_ADR, 1'b0);
      5'd18: word = mk_bj(CS_WAIT, 1'b0, 5'd0);
      5'd19: word = mk_bj(CS_WAIT, 1'b1, 5'd17);
      // second decode
      5'd20: word = mk_bj(CS_IR14, 1'b1, 5'd27);
      // add
      5'd21: word = mk_rt(PCO_HOLD, SRC_MEM_D, DST_MAR_ADR, 1'b0);
      5'd22: word = mk_rt(PCO_HOLD, SRC_MEM_D, DST_D_MBR,   1'b0);
      5'd23: word = mk_bj(CS_WAIT, 1'b1, 5'd22);
      5'd24: word = mk_rt(PCO_HOLD, SRC_ALU_R, DST_R_AC,    1'b1);
      5'd25: word = mk_bj(CS_WAIT, 1'b0, 5'd0);
      5'd26: word = mk_bj(CS_WAIT, 1'b1, 5'd0);
      // branch on zero
      5'd27: word = mk_bj(CS_ACZ, 1'b0, 5'd0);
      5'd28: word = mk_rt(PCO_LOAD, SRC_IR_A,  DST_NONE,    1'b0);
      5'd29: word = mk_bj(CS_ACZ, 1'b1, 5'd0);
      5'd30: word = mk_bj(CS_ACZ, 1'b0, 5'd0);
      default: word = '0;
    endcase
  end

endmodule

// File: rtl/usq_cond_mux.sv
module usq_cond_mux #(
  parameter int SW = 2,
  localparam int N = 1 << SW
) (
  input  logic [N-1:0]  cond_vec,
  input  logic [SW-1:0] sel,
  input  logic          val,
  output logic          take
);

  logic picked;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel == SW'(i)) picked = cond_vec[i];
    end
    take = (picked == val);
  end

endmodule

// File: rtl/usq_decode.sv
module usq_decode
  import usq_pkg::*;
(
  input  logic             active,
  input  logic [UW_W-1:0]  word,
  output logic [STB_N-1:0] src_stb,
  output logic [STB_N-1:0] dst_stb,
  output logic [PCS_N-1:0] pc_stb,
  output logic             alu_add,
  output logic             is_branch
);

  rt_word_t rw;
  logic     fire;

  assign rw   = rt_word_t'(word);
  assign fire = active & ~rw.fmt;

  for (genvar k = 1; k <= STB_N; k++) begin : g_bus
    assign src_stb[k-1] = fire & (rw.src == src_e'(k));
    assign dst_stb[k-1] = fire & (rw.dst == dst_e'(k));
  end

  for (genvar k = 1; k <= PCS_N; k++) begin : g_pc
    assign pc_stb[k-1] = fire & (rw.pc == pc_op_e'(k));
  end

  assign alu_add   = fire & rw.add;
  assign is_branch = active & rw.fmt;

endmodule

// File: rtl/usq_sequencer.sv
module usq_sequencer
  import usq_pkg::*;
#(
  parameter int RST_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mem_wait,
  input  logic             ir_bit15,
  input  logic             ir_bit14,
  input  logic             acc_zero,
  output logic [UA_W-1:0]  upc,
  output logic [STB_N-1:0] src_stb,
  output logic [STB_N-1:0] dst_stb,
  output logic [PCS_N-1:0] pc_stb,
  output logic             alu_add,
  output logic             is_branch
);

  localparam logic [UA_W-1:0] ONE = UA_W'(1);

  // reset release synchronizer
  logic [RST_SYNC-1:0] rs_q;
  logic                active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RST_SYNC-2:0], 1'b1};
  end

  assign active = rs_q[RST_SYNC-1];

  // control store and condition select
  logic [UA_W-1:0]   upc_q, upc_d;
  logic              upc_en;
  logic [UW_W-1:0]   uword;
  bj_word_t          bw;
  logic [COND_N-1:0] cond_vec;
  logic              take;

  usq_store u_store (
    .addr (upc_q),
    .word (uword)
  );

  assign bw       = bj_word_t'(uword);
  assign cond_vec = {acc_zero, ir_bit14, ir_bit15, mem_wait};

  usq_cond_mux #(.SW(SEL_W)) u_cond (
    .cond_vec (cond_vec),
    .sel      (bw.sel),
    .val      (bw.val),
    .take     (take)
  );

  // next address
  always_comb begin
    upc_d = upc_q;
    if (bw.fmt && take) upc_d = bw.tgt;
    else                upc_d = upc_q + ONE;
  end

  assign upc_en = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upc_q <= '0;
    else if (upc_en) upc_q <= upc_d;
  end

  assign upc = upc_q;

  usq_decode u_dec (
    .active    (active),
    .word      (uword),
    .src_stb   (src_stb),
    .dst_stb   (dst_stb),
    .pc_stb    (pc_stb),
    .alu_add   (alu_add),
    .is_branch (is_branch)
  );

  // R1: address parked at zero until the synchronizer releases
  a_r1_park_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (upc_q == '0));

  // R1: no strobes before release
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (src_stb == '0 && dst_stb == '0 && pc_stb == '0 && !alu_add && !is_branch));

  // R3: sequential step after a register-transfer word
  a_r3_rt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !is_branch) |=> (upc_q == UA_W'($past(upc_q) + ONE)));

  // R4: taken branch loads the target
  a_r4_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && take) |=> (upc_q == $past(bw.tgt)));

  // R5: branch not taken falls through
  a_r5_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && !take) |=> (upc_q == UA_W'($past(upc_q) + ONE)));

  // R6: branch words drive no datapath strobes
  a_r6_bj_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    is_branch |-> (src_stb == '0 && dst_stb == '0 && pc_stb == '0 && !alu_add));

  // R7: bus decoders are one-hot or idle
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_stb) && $onehot0(dst_stb));

  // R8: program-counter actions are mutually exclusive
  a_r8_pc_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pc_stb));

endmodule

// File: tb/tb_usq_sequencer.sv
module tb_usq_sequencer;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mem_wait, ir_bit15, ir_bit14, acc_zero;
  logic [4:0] upc;
  logic [6:0] src_stb, dst_stb;
  logic [2:0] pc_stb;
  logic       alu_add, is_branch;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  usq_sequencer dut (
    .clk (clk), .rst_n (rst_n),
    .mem_wait (mem_wait), .ir_bit15 (ir_bit15), .ir_bit14 (ir_bit14), .acc_zero (acc_zero),
    .upc (upc), .src_stb (src_stb), .dst_stb (dst_stb), .pc_stb (pc_stb),
    .alu_add (alu_add), .is_branch (is_branch)
  );

  // encodings from R2, R4, R7, R8, R9
  function automatic logic [9:0] rt(int p, int s, int d, int a);
    return {1'b0, 2'(p), 3'(s), 3'(d), 1'(a)};
  endfunction

  function automatic logic [9:0] bj(int c, int v, int t);
    return {1'b1, 2'(c), 1'(v), 1'b0, 5'(t)};
  endfunction

  // program of R11
  function automatic logic [9:0] ref_word(logic [4:0] a);
    case (a)
      5'd0:  return rt(2, 1, 2, 0);
      5'd1:  return rt(0, 6, 6, 0);
      5'd2:  return bj(0, 0, 1);
      5'd3:  return rt(0, 6, 5, 0);
      5'd4:  return bj(0, 1, 3);
      5'd5:  return rt(0, 3, 1, 0);
      5'd6:  return bj(0, 0, 5);
      5'd7:  return rt(0, 2, 2, 0);
      5'd8:  return bj(1, 1, 20);
      5'd9:  return bj(2, 1, 16);
      5'd10: return rt(0, 6, 6, 0);
      5'd11: return rt(0, 6, 5, 0);
      5'd12: return bj(0, 1, 11);
      5'd13: return rt(0, 5, 3, 0);
      5'd14: return bj(0, 0, 0);
      5'd15: return bj(0, 1, 0);
      5'd16: return rt(0, 4, 4, 0);
      5'd17: return rt(0, 7, 6, 0);
      5'd18: return bj(0, 0, 0);
      5'd19: return bj(0, 1, 17);
      5'd20: return bj(2, 1, 27);
      5'd21: return rt(0, 6, 6, 0);
      5'd22: return rt(0, 6, 5, 0);
      5'd23: return bj(0, 1, 22);
      5'd24: return rt(0, 5, 3, 1);
      5'd25: return bj(0, 0, 0);
      5'd26: return bj(0, 1, 0);
      5'd27: return bj(3, 0, 0);
      5'd28: return rt(3, 2, 0, 0);
      5'd29: return bj(3, 1, 0);
      5'd30: return bj(3, 0, 0);
      default: return 10'd0;
    endcase
  endfunction

  function automatic logic [6:0] dec7(logic [2:0] code);
    return (code == 3'd0) ? 7'd0 : (7'd1 << (code - 3'd1));
  endfunction

  function automatic logic [2:0] dec3(logic [1:0] code);
    return (code == 2'd0) ? 3'd0 : (3'd1 << (code - 2'd1));
  endfunction

  // R12 selection order
  function automatic logic pick_cond(logic [1:0] sel);
    case (sel)
      2'd0: return mem_wait;
      2'd1: return ir_bit15;
      2'd2: return ir_bit14;
      default: return acc_zero;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(string tag);
    chk({tag, " upc"}, upc, 0);
    chk({tag, " src"}, src_stb, 0);
    chk({tag, " dst"}, dst_stb, 0);
    chk({tag, " pc"}, pc_stb, 0);
    chk({tag, " alu"}, alu_add, 0);
    chk({tag, " br"}, is_branch, 0);
  endtask

  task automatic chk_word(logic [4:0] a);
    logic [9:0] w;
    w = ref_word(a);
    chk("R2 is_branch", is_branch, w[9]);
    if (w[9]) begin
      chk("R6 src quiet", src_stb, 0);
      chk("R6 dst quiet", dst_stb, 0);
      chk("R6 pc quiet", pc_stb, 0);
      chk("R6 alu quiet", alu_add, 0);
    end else begin
      chk("R7 src", src_stb, dec7(w[6:4]));
      chk("R7 dst", dst_stb, dec7(w[3:1]));
      chk("R8 pc", pc_stb, dec3(w[8:7]));
      chk("R9 alu_add", alu_add, w[0]);
    end
  endtask

  logic [4:0] mpc;
  string      tag;

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_idle("R1 in reset");
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_idle("R1 release window");
    @(posedge clk);
    mpc = 5'd0;
    tag = "R1 first word R11";
  endtask

  task automatic run(int cycles, int wait_pct);
    for (int i = 0; i < cycles; i++) begin
      logic [9:0] w;
      logic       tk;
      @(negedge clk);
      chk({tag, " upc"}, upc, mpc);
      chk_word(mpc);
      mem_wait = (($urandom % 100) < wait_pct);
      ir_bit15 = $urandom % 2;
      ir_bit14 = $urandom % 2;
      acc_zero = $urandom % 2;
      w = ref_word(mpc);
      if (w[9]) begin
        tk  = (pick_cond(w[8:7]) == w[6]);
        tag = tk ? "R4 taken" : "R5 fallthrough";
        if (mpc == 5'd2 && tk) tag = "R10 wait loop";
        if (w[8:7] != 2'd0) tag = {tag, " R12"};
        mpc = tk ? w[4:0] : mpc + 5'd1;
      end else begin
        tag = "R3 step";
        mpc = mpc + 5'd1;
      end
      tag = {tag, " R11"};
      @(posedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; mem_wait = 1'b0; ir_bit15 = 1'b0; ir_bit14 = 1'b0; acc_zero = 1'b0;
    mpc = '0;
    tag = "R1";
    do_reset();
    run(40, 20);     // long wait-loop stays at fetch
    run(2500, 75);
    do_reset();      // reset in the middle of a run
    run(1500, 60);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule